// File: doc/BRIEF.md
# Opcode-to-control decoder for a single-cycle datapath

This block turns the six-bit major opcode of a 32-bit instruction (instruction bits 31:26) into the steering and write-enable signals of a single-cycle datapath. It recognises six instruction kinds: register-register operations, OR with an immediate, word load, word store, branch-if-equal and unconditional jump. It has no clock and no state. Every output is a pure function of the opcode present in the same cycle.

The three-bit ALU intent output does not choose the arithmetic operation for register-register instructions. For those it emits a "look at the function field" code, and a separate local ALU control resolves the operation from the low six instruction bits. That local decode is outside this block. For an opcode the block does not recognise, every output is 0. The datapath then performs no register write, no memory write and no change of control flow, so an unknown opcode acts as a no-op.

The opcode is a plain control input with no handshake. The consumer samples the outputs in the same cycle in which it presents the opcode.

Top module: `main_ctl_decoder`

## Requirements
- R1: The recognised opcodes are 000000 (register-register), 001101 (OR immediate), 100011 (load), 101011 (store), 000100 (branch-if-equal) and 000010 (jump). For each one, the outputs form one fixed control word.
- R2: `reg_we` is 1 for opcodes 000000, 001101 and 100011, and 0 for every other opcode.
- R3: `dst_is_rd` is 1 (destination taken from bits 15:11) for opcode 000000 only. It is 0 (destination taken from bits 20:16) for all other opcodes.
- R4: `alu_src_imm` is 1 (second ALU operand is the extended immediate) for 001101, 100011 and 101011. It is 0 for all other opcodes.
- R5: `load_to_reg` is 1 only for 100011, and `mem_we` is 1 only for 101011.
- R6: `ext_signed` is 1 (sign extension) for 100011 and 101011. It is 0 (zero extension) for 001101 and for every other opcode.
- R7: `alu_intent` is 100 for 000000 (defer to the function field), 010 for 001101 (OR) and 001 for 000100 (subtract). It is 000 (add) for 100011, 101011, 000010 and every unrecognised opcode.
- R8: `branch_eq` is 1 only for 000100, and `jump` is 1 only for 000010.
- R9: For any of the 58 unrecognised opcodes, all outputs are 0.
- R10: The outputs depend only on the current opcode, with no clock, no memory of earlier opcodes and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Major opcode, instruction bits 31:26 |
| dst_is_rd | output | 1 | Destination register select: 1 = bits 15:11, 0 = bits 20:16 |
| alu_src_imm | output | 1 | Second ALU operand: 1 = extended immediate, 0 = register |
| load_to_reg | output | 1 | Write-back source: 1 = data memory, 0 = ALU result |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| branch_eq | output | 1 | Take branch when ALU zero flag is set |
| jump | output | 1 | Unconditional jump |
| ext_signed | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_intent | output | 3 | ALU intent code for the local ALU control |

## Verification
The same opcode drives both the recognised-instruction decode and the unknown-opcode no-op fallback, and a single bit flip moves an opcode from one path to the other. Each valid opcode is presented directly after a neighbour one bit away, and all 64 codes are swept in sequence. Each result is judged against the expected control word for the current opcode alone. The register-write and memory-write enables, and the branch and jump flags, are also checked never to be high together for any opcode.

// File: rtl/main_ctl_decoder_pkg.sv
package main_ctl_decoder_pkg;

  localparam int OP_W    = 6;
  localparam int INTENT_W = 3;
  localparam int N_KIND  = 6;

  typedef enum logic [INTENT_W-1:0] {
    INT_ADD  = 3'b000,
    INT_SUB  = 3'b001,
    INT_OR   = 3'b010,
    INT_FUNC = 3'b100
  } intent_e;

  typedef enum int {
    K_REGOP = 0,
    K_ORIMM = 1,
    K_LOAD  = 2,
    K_STORE = 3,
    K_BEQ   = 4,
    K_JUMP  = 5
  } kind_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    alu_src_imm;
    logic    load_to_reg;
    logic    reg_we;
    logic    mem_we;
    logic    branch_eq;
    logic    jump;
    logic    ext_signed;
    intent_e intent;
  } ctl_word_t;

  localparam ctl_word_t CTL_IDLE = '{default: '0, intent: INT_ADD};

  function automatic logic [OP_W-1:0] kind_opcode(input int k);
    case (k)
      K_REGOP: return 6'b000000;
      K_ORIMM: return 6'b001101;
      K_LOAD:  return 6'b100011;
      K_STORE: return 6'b101011;
      K_BEQ:   return 6'b000100;
      default: return 6'b000010;
    endcase
  endfunction

  function automatic ctl_word_t kind_row(input int k);
    ctl_word_t w;
    w = CTL_IDLE;
    case (k)
      K_REGOP: begin w.dst_is_rd = 1'b1; w.reg_we = 1'b1; w.intent = INT_FUNC; end
      K_ORIMM: begin w.alu_src_imm = 1'b1; w.reg_we = 1'b1; w.intent = INT_OR; end
      K_LOAD:  begin
        w.alu_src_imm = 1'b1; w.load_to_reg = 1'b1; w.reg_we = 1'b1; w.ext_signed = 1'b1;
      end
      K_STORE: begin w.alu_src_imm = 1'b1; w.mem_we = 1'b1; w.ext_signed = 1'b1; end
      K_BEQ:   begin w.branch_eq = 1'b1; w.intent = INT_SUB; end
      default: begin w.jump = 1'b1; end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/opcode_kind_match.sv
module opcode_kind_match
  import main_ctl_decoder_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  output logic [N_KIND-1:0] hit
);

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    assign hit[k] = (op == kind_opcode(k));
  end

  always_comb begin
    if (!$isunknown(op)) begin
      // R1
      kind_onehot_chk: assert ($onehot0(hit))
        else $error("opcode %b matched several kinds", op);
    end
  end

endmodule

// File: rtl/ctl_word_merge.sv
module ctl_word_merge
  import main_ctl_decoder_pkg::*;
(
  input  logic [N_KIND-1:0] hit,
  output ctl_word_t         word
);

  ctl_word_t rows [N_KIND];

  for (genvar k = 0; k < N_KIND; k++) begin : g_row
    assign rows[k] = hit[k] ? kind_row(k) : CTL_IDLE;
  end

  always_comb begin
    word = CTL_IDLE;
    for (int k = 0; k < N_KIND; k++) begin
      word = word | rows[k];
    end
  end

  always_comb begin
    if (!$isunknown(word)) begin
      // R5
      reg_mem_excl_chk: assert (!(word.reg_we && word.mem_we))
        else $error("register and memory write together");
      // R8
      branch_jump_excl_chk: assert (!(word.branch_eq && word.jump))
        else $error("branch and jump together");
      // R5
      load_path_chk: assert (!word.load_to_reg || (word.reg_we && !word.dst_is_rd && word.alu_src_imm))
        else $error("load write-back without matching steering");
      // R6
      store_addr_chk: assert (!word.mem_we || (word.alu_src_imm && word.ext_signed))
        else $error("store address not sign-extended immediate");
    end
  end

endmodule

// File: rtl/main_ctl_decoder.sv
module main_ctl_decoder
  import main_ctl_decoder_pkg::*;
(
  input  logic [5:0] op_code,
  output logic       dst_is_rd,
  output logic       alu_src_imm,
  output logic       load_to_reg,
  output logic       reg_we,
  output logic       mem_we,
  output logic       branch_eq,
  output logic       jump,
  output logic       ext_signed,
  output logic [2:0] alu_intent
);

  logic [N_KIND-1:0] hit;
  ctl_word_t         word;

  opcode_kind_match u_match (
    .op  (op_code),
    .hit (hit)
  );

  ctl_word_merge u_merge (
    .hit  (hit),
    .word (word)
  );

  assign dst_is_rd   = word.dst_is_rd;
  assign alu_src_imm = word.alu_src_imm;
  assign load_to_reg = word.load_to_reg;
  assign reg_we      = word.reg_we;
  assign mem_we      = word.mem_we;
  assign branch_eq   = word.branch_eq;
  assign jump        = word.jump;
  assign ext_signed  = word.ext_signed;
  assign alu_intent  = word.intent;

  always_comb begin
    if (!$isunknown({hit, word})) begin
      // R9
      unknown_noop_chk: assert ((|hit) || (word == CTL_IDLE))
        else $error("unrecognised opcode %b produced controls", op_code);
    end
  end

endmodule

// File: tb/sim_main_ctl_decoder.sv
module sim_main_ctl_decoder;

  localparam time CLK_PERIOD = 10ns;
  localparam int  N_VEC = 6;
  // {opcode, dst, src, m2r, rwe, mwe, br, j, ext, intent[2:0]}
  localparam logic [16:0] VEC [N_VEC] = '{
    {6'b000000, 8'b1001_0000, 3'b100},
    {6'b001101, 8'b0101_0000, 3'b010},
    {6'b100011, 8'b0111_0001, 3'b000},
    {6'b101011, 8'b0100_1001, 3'b000},
    {6'b000100, 8'b0000_0100, 3'b001},
    {6'b000010, 8'b0000_0010, 3'b000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] op_code = 6'b111111;
  logic dst_is_rd, alu_src_imm, load_to_reg, reg_we, mem_we, branch_eq, jump, ext_signed;
  logic [2:0] alu_intent;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  main_ctl_decoder u0 (
    .op_code(op_code), .dst_is_rd(dst_is_rd), .alu_src_imm(alu_src_imm),
    .load_to_reg(load_to_reg), .reg_we(reg_we), .mem_we(mem_we),
    .branch_eq(branch_eq), .jump(jump), .ext_signed(ext_signed), .alu_intent(alu_intent)
  );

  function automatic logic [10:0] outs();
    return {dst_is_rd, alu_src_imm, load_to_reg, reg_we, mem_we, branch_eq, jump, ext_signed, alu_intent};
  endfunction

  task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b actual=%b expected=%b", req, op_code, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op);
    @(negedge clk);
    op_code = op;
    #1;
  endtask

  function automatic logic [10:0] expect_for(input logic [5:0] op);
    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][16:11] == op) return VEC[i][10:0];
    end
    return 11'b0;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R9: idle opcode after reset gives all zeros
    chk("R9", outs(), 11'b0);

    // R1: table walk, full control word
    for (int i = 0; i < N_VEC; i++) begin
      apply(VEC[i][16:11]);
      chk("R1", outs(), VEC[i][10:0]);
      chk("R2", {10'b0, reg_we},      {10'b0, VEC[i][7]});
      chk("R3", {10'b0, dst_is_rd},   {10'b0, VEC[i][10]});
      chk("R4", {10'b0, alu_src_imm}, {10'b0, VEC[i][9]});
      chk("R5", {9'b0, load_to_reg, mem_we}, {9'b0, VEC[i][8], VEC[i][6]});
      chk("R6", {10'b0, ext_signed},  {10'b0, VEC[i][3]});
      chk("R7", {8'b0, alu_intent},   {8'b0, VEC[i][2:0]});
      chk("R8", {9'b0, branch_eq, jump}, {9'b0, VEC[i][5], VEC[i][4]});
    end

    // R9: one-bit neighbours of each valid opcode, then the valid one right after
    for (int i = 0; i < N_VEC; i++) begin
      for (int b = 0; b < 6; b++) begin
        logic [5:0] nb;
        nb = VEC[i][16:11] ^ (6'b1 << b);
        apply(nb);
        chk("R9", outs(), expect_for(nb));
        apply(VEC[i][16:11]);
        chk("R10", outs(), VEC[i][10:0]);
      end
    end

    // R9: full sweep of every opcode
    for (int c = 0; c < 64; c++) begin
      apply(c[5:0]);
      chk("R9", outs(), expect_for(c[5:0]));
    end

    // R10: change within a cycle, no clock edge in between
    @(negedge clk);
    op_code = 6'b100011;
    #1;
    chk("R10", outs(), VEC[2][10:0]);
    op_code = 6'b101011;
    #1;
    chk("R10", outs(), VEC[3][10:0]);
    op_code = 6'b111111;
    #1;
    chk("R10", outs(), 11'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule